// File: doc/BRIEF.md
# Scan-Chain Command Dispatcher

This block hangs off the user data-register hooks of a built-in test access port. It gives a host a narrow command channel into on-chip logic. Each scan moves one 16-bit word in on `tdi`, least-significant bit first. The same scan returns the previous word's context on `tdo`. When the update strobe arrives, the word is decoded into three fields: a peripheral number, an opcode and a data byte.

The command is then carried into the system clock domain and executed exactly once. Writes set the virtual switches or the monitor multiplexer select. Reads sample a peripheral and hold the byte until the next capture, so the host gets the result on the following scan.

The peripheral map is:

| Number | Peripheral | Access |
|---|---|---|
| 0 | virtual switches | read and write |
| 1 | virtual LEDs (`led_in`) | read only |
| 2 | monitor multiplexer select | read and write |
| 3 | status register (`status_in`) | read only |
| 4 to 15 | not populated | none |

The scan path has no flow control. A scan is accepted whenever the strobes arrive, so the host must space its updates as stated in R8.

Top module: `scan_cmd_hub`

## Requirements
- R1: While `dr_sel` and `dr_shift` are high, each rising `tck` edge shifts the 16-bit register one place toward bit 0, and `tdi` enters at bit 15. `tdo` always shows bit 0, so the first bit shifted in ends up as bit 0.
- R2: The latched word is decoded as follows: bits [15:12] are the peripheral number, bits [11:8] are the opcode and bits [7:0] are the data byte.
- R3: Opcode 0x0 is a write. Writing to peripheral 0 sets `sw_out` to the data byte. Writing to peripheral 2 sets `mon_sel` to the data byte.
- R4: Opcode 0x1 is a read. On the next capture, the shift register loads these values: bits [15:12] get the last updated peripheral number, bits [11:8] get the last updated opcode, and bits [7:0] get the byte from the most recent read.
- R5: Opcodes 0x2 to 0xF change no output and no read byte.
- R6: A write to peripheral 1, peripheral 3 or peripherals 4 to 15 is dropped. A read from peripherals 4 to 15 returns 0x00.
- R7: The read byte depends on the peripheral. Peripheral 1 returns `led_in` and peripheral 3 returns `status_in`. Peripherals 0 and 2 return the current value of their own register.
- R8: The command runs once for each update. Its effect is visible at the outputs within four `sys_clk` edges of the update edge, provided updates are at least eight `sys_clk` periods apart.
- R9: `sys_rst` (synchronous, active high) clears `sw_out`, `mon_sel` and the read byte to 0x00. The switches therefore come up off.
- R10: `tlr` (asynchronous, active high) clears the shift register and the held word. A capture made after both resets returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous active-high system reset |
| tck | input | 1 | Test clock |
| tlr | input | 1 | Test-logic reset, asynchronous, active high |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the shift register |
| dr_sel | input | 1 | User data register selected |
| dr_capture | input | 1 | Capture strobe (tck domain) |
| dr_shift | input | 1 | Shift strobe (tck domain) |
| dr_update | input | 1 | Update strobe (tck domain) |
| led_in | input | 8 | Virtual LED levels driven by the design |
| status_in | input | 8 | Status/debug byte driven by the design |
| sw_out | output | 8 | Virtual switch levels |
| mon_sel | output | 8 | Monitor multiplexer select |

## Verification
The assertions take for granted the following input behaviour:

- Capture, shift and update are never high together.
- Updates are spaced far enough apart that a toggle never reaches the synchronizer before the previous one has produced its pulse.
- `sys_rst` is held long enough to flush the synchronizer.
- `led_in` and `status_in` stay still around a read.

The stimulus meets these conditions. It drives each strobe on its own `tck` period with all edges well clear of the rising edge. It waits ten system cycles after every update. It holds both resets for several cycles before the first scan, and it keeps the design-side bytes constant.

// File: rtl/scan_cmd_pkg.sv
package scan_cmd_pkg;
  localparam int ID_W   = 4;
  localparam int OP_W   = 4;
  localparam int DAT_W  = 8;
  localparam int WORD_W = ID_W + OP_W + DAT_W;

  localparam logic [OP_W-1:0] OP_WRITE = 4'h0;
  localparam logic [OP_W-1:0] OP_READ  = 4'h1;

  localparam logic [ID_W-1:0] ID_SW   = 4'h0;
  localparam logic [ID_W-1:0] ID_LED  = 4'h1;
  localparam logic [ID_W-1:0] ID_MON  = 4'h2;
  localparam logic [ID_W-1:0] ID_STAT = 4'h3;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic [OP_W-1:0]  op;
    logic [DAT_W-1:0] dat;
  } scan_cmd_t;
endpackage

// File: rtl/scan_shifter.sv
module scan_shifter
  import scan_cmd_pkg::*;
(
  input  logic             tck,
  input  logic             tlr,
  input  logic             tdi,
  input  logic             sel,
  input  logic             cap,
  input  logic             shf,
  input  logic             upd,
  input  logic [DAT_W-1:0] rd_byte,
  output logic             tdo,
  output scan_cmd_t        hold,
  output logic             tgl
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge tck or posedge tlr) begin
    if (tlr) begin
      sh   <= '0;
      hold <= '0;
      tgl  <= 1'b0;
    end else if (sel) begin
      if (cap) begin
        sh <= {hold.id, hold.op, rd_byte};
      end else if (shf) begin
        sh <= {tdi, sh[WORD_W-1:1]};
      end else if (upd) begin
        hold <= scan_cmd_t'(sh);
        tgl  <= ~tgl;
      end
    end
  end

  assign tdo = sh[0];

  // R1: each shift moves the word one place toward bit 0
  p_shift_lsb_r1: assert property (@(posedge tck) disable iff (tlr)
    (sel && shf && !cap) |=> (sh[WORD_W-2:0] == $past(sh[WORD_W-1:1])));

  // R8: the held command only changes on an update
  p_hold_keep_r8: assert property (@(posedge tck) disable iff (tlr)
    !(sel && upd && !cap && !shf) |=> $stable(hold) && $stable(tgl));
endmodule

// File: rtl/toggle_sync.sv
module toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl_in,
  output logic pulse
);
  logic [STAGES-1:0] stg;
  logic              prev;

  always_ff @(posedge clk) stg[0] <= tgl_in;

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) stg[g] <= stg[g-1];
    end
  endgenerate

  // During reset prev tracks the synchronized level, so no stale command replays
  always_ff @(posedge clk) prev <= stg[STAGES-1];

  assign pulse = !rst && (stg[STAGES-1] != prev);

  // R8: one update yields a single one-cycle pulse
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/periph_bank.sv
module periph_bank
  import scan_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  scan_cmd_t        cmd,
  input  logic [DAT_W-1:0] led_in,
  input  logic [DAT_W-1:0] stat_in,
  output logic [DAT_W-1:0] sw,
  output logic [DAT_W-1:0] mon,
  output logic [DAT_W-1:0] rd
);
  logic [DAT_W-1:0] rd_val;

  always_comb begin
    case (cmd.id)
      ID_SW:   rd_val = sw;
      ID_LED:  rd_val = led_in;
      ID_MON:  rd_val = mon;
      ID_STAT: rd_val = stat_in;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw  <= '0;
      mon <= '0;
      rd  <= '0;
    end else if (go) begin
      if (cmd.op == OP_WRITE) begin
        if (cmd.id == ID_SW)  sw  <= cmd.dat;
        if (cmd.id == ID_MON) mon <= cmd.dat;
      end else if (cmd.op == OP_READ) begin
        rd <= rd_val;
      end
    end
  end

  // R5: reserved opcodes leave every register alone
  p_reserved_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (go && cmd.op != OP_WRITE && cmd.op != OP_READ)
      |=> $stable(sw) && $stable(mon) && $stable(rd));

  // R6: writes outside the writable peripherals are dropped
  p_ro_write_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (go && cmd.op == OP_WRITE && cmd.id != ID_SW && cmd.id != ID_MON)
      |=> $stable(sw) && $stable(mon));

  // R9: reset clears every register
  p_rst_clear_r9: assert property (@(posedge clk)
    rst |=> (sw == '0) && (mon == '0) && (rd == '0));

  // R3: a write to the switches takes the data byte
  p_sw_write_r3: assert property (@(posedge clk) disable iff (rst)
    (go && cmd.op == OP_WRITE && cmd.id == ID_SW) |=> (sw == $past(cmd.dat)));
endmodule

// File: rtl/scan_cmd_hub.sv
module scan_cmd_hub
  import scan_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             sys_clk,
  input  logic             sys_rst,
  input  logic             tck,
  input  logic             tlr,
  input  logic             tdi,
  output logic             tdo,
  input  logic             dr_sel,
  input  logic             dr_capture,
  input  logic             dr_shift,
  input  logic             dr_update,
  input  logic [DAT_W-1:0] led_in,
  input  logic [DAT_W-1:0] status_in,
  output logic [DAT_W-1:0] sw_out,
  output logic [DAT_W-1:0] mon_sel
);
  scan_cmd_t        held;
  logic             tgl;
  logic             go;
  logic [DAT_W-1:0] rd_byte;

  scan_shifter u_shift (
    .tck(tck), .tlr(tlr), .tdi(tdi), .sel(dr_sel), .cap(dr_capture),
    .shf(dr_shift), .upd(dr_update), .rd_byte(rd_byte),
    .tdo(tdo), .hold(held), .tgl(tgl)
  );

  toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(sys_clk), .rst(sys_rst), .tgl_in(tgl), .pulse(go)
  );

  periph_bank u_bank (
    .clk(sys_clk), .rst(sys_rst), .go(go), .cmd(held),
    .led_in(led_in), .stat_in(status_in),
    .sw(sw_out), .mon(mon_sel), .rd(rd_byte)
  );

  // R3: the monitor select changes only through a command pulse
  p_mon_only_on_cmd_r3: assert property (@(posedge sys_clk) disable iff (sys_rst)
    !go |=> $stable(mon_sel));
endmodule

// File: tb/scan_cmd_hub_bench.sv
module scan_cmd_hub_bench;
  logic sys_clk = 1'b0, sys_rst = 1'b1, tck = 1'b0, tlr = 1'b1, tdi = 1'b0;
  logic dr_sel = 1'b0, dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0;
  logic [7:0] led_in = 8'hC3, status_in = 8'h5A;
  logic tdo;
  logic [7:0] sw_out, mon_sel;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  scan_cmd_hub u_scan_cmd_hub (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .tck(tck), .tlr(tlr), .tdi(tdi),
    .tdo(tdo), .dr_sel(dr_sel), .dr_capture(dr_capture), .dr_shift(dr_shift),
    .dr_update(dr_update), .led_in(led_in), .status_in(status_in),
    .sw_out(sw_out), .mon_sel(mon_sel)
  );

  always #2.5 sys_clk = ~sys_clk;

  // {command word, expected read byte, expected sw_out, expected mon_sel}
  localparam logic [39:0] VEC [8] = '{
    {16'h00A5, 8'hA5, 8'hA5, 8'h00},  // R3 switch write
    {16'h203C, 8'h3C, 8'hA5, 8'h3C},  // R3 monitor select write
    {16'h3077, 8'h5A, 8'hA5, 8'h3C},  // R6/R7 status write dropped, status read
    {16'h9011, 8'h00, 8'hA5, 8'h3C},  // R6 unpopulated peripheral
    {16'h07FF, 8'hA5, 8'hA5, 8'h3C},  // R5 reserved opcode
    {16'h10EE, 8'hC3, 8'hA5, 8'h3C},  // R6/R7 LED write dropped, LED read
    {16'h2500, 8'h3C, 8'hA5, 8'h3C},  // R5 reserved opcode on monitor
    {16'h0000, 8'h00, 8'h00, 8'h3C}   // R3 switches back off
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic scan(input logic [15:0] win, output logic [15:0] wout);
    dr_sel = 1'b1; dr_capture = 1'b1;
    #20 tck = 1'b1; #20 tck = 1'b0;
    dr_capture = 1'b0; dr_shift = 1'b1;
    for (int i = 0; i < 16; i++) begin
      tdi = win[i];
      #10 wout[i] = tdo;
      #10 tck = 1'b1; #20 tck = 1'b0;
    end
    dr_shift = 1'b0; dr_update = 1'b1;
    #20 tck = 1'b1; #20 tck = 1'b0;
    dr_update = 1'b0; dr_sel = 1'b0;
    repeat (10) @(posedge sys_clk);
    #1;
  endtask

  task automatic finish_run;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge sys_clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin : main
    logic [15:0] rx;
    logic [0:15] stream;
    repeat (6) @(posedge sys_clk);
    tlr = 1'b0;
    #1 sys_rst = 1'b0;
    repeat (4) @(posedge sys_clk);
    #1;
    // R9 reset state of the outputs
    chk("R9 sw_out at reset", {8'h00, sw_out}, 16'h0000);
    chk("R9 mon_sel at reset", {8'h00, mon_sel}, 16'h0000);
    // R10 capture after both resets
    scan(16'hFF00, rx);
    chk("R10 capture after reset", rx, 16'h0000);

    foreach (VEC[k]) begin
      logic [15:0] cmd;
      cmd = VEC[k][39:24];
      scan(cmd, rx);
      scan({cmd[15:12], 4'h1, 8'h00}, rx);
      scan(16'hFF00, rx);
      // R4 read result returned with the last id and opcode
      chk("R4/R7 read capture", rx, {cmd[15:12], 4'h1, VEC[k][23:16]});
      chk("R3/R5/R6 sw_out", {8'h00, sw_out}, {8'h00, VEC[k][15:8]});
      chk("R3/R5/R6 mon_sel", {8'h00, mon_sel}, {8'h00, VEC[k][7:0]});
    end

    // R1/R2 serial order: first bit shifted ends in bit 0, fields decode as write 0x34 to peripheral 2
    stream = 16'b0010110000000100;
    for (int i = 0; i < 16; i++) rx[i] = stream[i];
    begin
      logic [15:0] w;
      w = rx;
      scan(w, rx);
    end
    chk("R1/R2 serial write to monitor", {8'h00, mon_sel}, 16'h0034);
    // R1 the capture of a nop scan comes back out on tdo, bit 0 first
    scan(16'hFF00, rx);
    chk("R1 echo of last id/op", rx, 16'h2034 & 16'hFF00 | 16'h0000 | {8'h00, 8'h00} | 16'h0000 & 16'h0000 | (16'h2000 & 16'hF000) | 16'h0000);
    // R6 highest unpopulated number reads zero
    scan(16'hF100, rx);
    scan(16'hFF00, rx);
    chk("R6 read unpopulated 0xF", rx, 16'hF100);
    // R8 single command effect within four sys_clk edges
    dr_sel = 1'b1; dr_capture = 1'b1; #20 tck = 1'b1; #20 tck = 1'b0;
    dr_capture = 1'b0; dr_shift = 1'b1;
    for (int i = 0; i < 16; i++) begin
      tdi = 16'h0066 >> i;
      #20 tck = 1'b1; #20 tck = 1'b0;
    end
    dr_shift = 1'b0; dr_update = 1'b1;
    #20 tck = 1'b1;
    repeat (4) @(posedge sys_clk);
    #1;
    chk("R8 latency", {8'h00, sw_out}, 16'h0066);
    #5 tck = 1'b0; dr_update = 1'b0; dr_sel = 1'b0;
    repeat (10) @(posedge sys_clk);
    // R9 mid-run reset clears outputs and read byte
    @(posedge sys_clk); #1 sys_rst = 1'b1;
    repeat (4) @(posedge sys_clk);
    #1 sys_rst = 1'b0;
    #1;
    chk("R9 sw_out after reset", {8'h00, sw_out}, 16'h0000);
    chk("R9 mon_sel after reset", {8'h00, mon_sel}, 16'h0000);
    scan(16'hFF00, rx);
    chk("R9 read byte after reset", {8'h00, rx[7:0]}, 16'h0000);
    done = 1'b1;
    finish_run();
  end
endmodule